// File: doc/BRIEF.md
# One-Time Fuse Program and Read Controller

This block is a register-mapped front end for a small one-time-programmable bit array. The array is modelled as non-volatile storage of 256 rows of 32 bits inside the block. Software sets single bits and reads whole rows. Each operation starts when software writes a packed row/column value into one of two trigger registers. The controller first checks the program-enable bit and the protection bits held in row 0. It then either updates the array or loads a read-data register, and raises a done or an error flag.

The flags collect in a write-one-to-clear interrupt status register. A mask register, which starts fully set, gates the flags onto one registered interrupt line. Software changes the mask only through a separate enable register and a separate disable register. A global write-lock register freezes every other register while it holds a nonzero value.

The register bus is a plain 32-bit, word-addressed, single-cycle interface. A read returns its data on the cycle after the read strobe. An accepted program occupies the array for one extra cycle, a read-modify-write. A trigger that arrives during that cycle is dropped and flagged.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: A trigger value carries the column index in bits 4:0 and the row index in bits 12:5.
- R2: The program trigger (word 2) and the read trigger (word 3) are write-only. Reading either one returns zero.
- R3: While the program-enable bit (bit 0 of the control register, word 0) is clear, a program request sets the program-error flag (status bit 2) and leaves the array unchanged.
- R4: An enabled program request to an unprotected bit sets that bit and raises program-done (status bit 1 is not used for this; program-done is status bit 0). A request to a protected bit raises program-error (bit 2) and changes nothing.
- R5: Programming only ever sets bits. Reprogramming a set bit, or programming a new bit, keeps every other bit of the row.
- R6: A read of an unblocked row copies the row into the read-data register (word 4) and raises read-done (status bit 1). A read of a blocked row raises read-error (bit 3) and leaves the read-data register unchanged.
- R7: The interrupt output is registered. It equals the OR of (status AND NOT mask) from the previous cycle.
- R8: The mask (word 6) resets to 0x10F. Writing ones to word 7 clears those mask bits, and writing ones to word 8 sets them. Writes to word 6 have no effect.
- R9: While the write-lock register (word 1) is nonzero, every write except one to word 1 is ignored, including trigger writes.
- R10: A trigger written while a program is still in its write-back cycle is dropped and sets the request-error flag (status bit 8).
- R11: The status register (word 5) resets to zero and clears the bits written as ones. An event arriving in the same cycle as the clear wins.
- R12: The lock map works from row 0. Bit 31 of row 0 protects row 0 itself. Bit 1 protects rows 8 to 11. Bit 2 protects rows 12 to 15. Bit 3 blocks reads of rows 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Masked interrupt, registered |

## Verification
The bench sweeps all 32 columns of one row, so a misplaced column field or a program that overwrites the row shows up as a wrong accumulated value. It walks the boundaries of each lock group (rows 7, 8, 11, 12, 15 and 16). A map off by one row would either accept a program into a protected row or refuse a free one. Reads of a blocked row must leave the previous read data in place, which catches a design that loads the register before it checks the block. A back-to-back trigger pair checks that the second request is dropped and flagged rather than run against a half-written row. A locked register file must also ignore triggers and mask changes, not only writes to the control register.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] RA_WLOCK = 4'd1;
  localparam logic [REG_AW-1:0] RA_PGM   = 4'd2;
  localparam logic [REG_AW-1:0] RA_RD    = 4'd3;
  localparam logic [REG_AW-1:0] RA_RDATA = 4'd4;
  localparam logic [REG_AW-1:0] RA_ISR   = 4'd5;
  localparam logic [REG_AW-1:0] RA_IMR   = 4'd6;
  localparam logic [REG_AW-1:0] RA_IER   = 4'd7;
  localparam logic [REG_AW-1:0] RA_IDR   = 4'd8;

  localparam int IRQ_W        = 9;
  localparam int IRQ_PGM_DONE = 0;
  localparam int IRQ_RD_DONE  = 1;
  localparam int IRQ_PGM_ERR  = 2;
  localparam int IRQ_RD_ERR   = 3;
  localparam int IRQ_REQ_ERR  = 8;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 9'h10F;

  // lock fuse positions in row 0 and the row groups they guard
  localparam int LK_GRP_A  = 1;
  localparam int LK_GRP_B  = 2;
  localparam int RB_GRP_B  = 3;
  localparam int GRP_A_LO  = 8;
  localparam int GRP_A_HI  = 11;
  localparam int GRP_B_LO  = 12;
  localparam int GRP_B_HI  = 15;

  typedef struct packed {
    logic self_lk;
    logic grp_a;
    logic grp_b;
    logic rblk_b;
  } lock_bits_t;

  typedef struct packed {
    logic pgm_done;
    logic rd_done;
    logic pgm_err;
    logic rd_err;
    logic req_err;
  } otp_ev_t;
endpackage

// File: rtl/otp_lockmap.sv
module otp_lockmap
  import otp_pkg::*;
#(
  parameter int ROWS = 256
) (
  input  lock_bits_t                 lk,
  input  logic [$clog2(ROWS)-1:0]    row,
  output logic                       pgm_locked,
  output logic                       rd_blocked
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] A_LO = ROW_W'(GRP_A_LO);
  localparam logic [ROW_W-1:0] A_HI = ROW_W'(GRP_A_HI);
  localparam logic [ROW_W-1:0] B_LO = ROW_W'(GRP_B_LO);
  localparam logic [ROW_W-1:0] B_HI = ROW_W'(GRP_B_HI);

  logic in_a, in_b, is_lock_row;

  always_comb begin
    in_a        = (row >= A_LO) && (row <= A_HI);
    in_b        = (row >= B_LO) && (row <= B_HI);
    is_lock_row = (row == '0);
    pgm_locked  = (is_lock_row && lk.self_lk) ||
                  (in_a && lk.grp_a) ||
                  (in_b && lk.grp_b);
    rd_blocked  = in_b && lk.rblk_b;
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ROWS = 256,
  parameter int COLS = 32
) (
  input  logic                    clk,
  input  logic                    re,
  input  logic [$clog2(ROWS)-1:0] raddr,
  output logic [COLS-1:0]         q,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] waddr,
  input  logic [COLS-1:0]         wd
);
  logic [COLS-1:0] mem [ROWS] = '{default: '0};
  logic [COLS-1:0] q_r = '0;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    if (re) q_r <= mem[raddr];
  end

  assign q = q_r;
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 32
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     trig_pgm,
  input  logic                                     trig_rd,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]     trig_addr,
  input  logic                                     pgm_en,
  output logic                                     mem_re,
  output logic [$clog2(ROWS)-1:0]                  mem_raddr,
  input  logic [COLS-1:0]                          mem_q,
  output logic                                     mem_we,
  output logic [$clog2(ROWS)-1:0]                  mem_waddr,
  output logic [COLS-1:0]                          mem_wd,
  output logic [COLS-1:0]                          rd_data,
  output otp_ev_t                                  ev
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int AW    = ROW_W + COL_W;

  typedef enum logic [1:0] {ST_IDLE, ST_PGM_WB, ST_RD_LD} st_e;

  st_e               state;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  lock_bits_t        lock_q = '0;
  logic [ROW_W-1:0]  t_row;
  logic [COL_W-1:0]  t_col;
  logic              pgm_locked, rd_blocked;
  logic              start_pgm, start_rd;

  assign t_row = trig_addr[AW-1:COL_W];
  assign t_col = trig_addr[COL_W-1:0];

  otp_lockmap #(.ROWS(ROWS)) u_lockmap (
    .lk         (lock_q),
    .row        (t_row),
    .pgm_locked (pgm_locked),
    .rd_blocked (rd_blocked)
  );

  always_comb begin
    ev        = '0;
    start_pgm = 1'b0;
    start_rd  = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = row_q;
    mem_wd    = mem_q | (COLS'(1) << col_q);
    if (state == ST_IDLE) begin
      if (trig_pgm) begin
        if (!pgm_en || pgm_locked) ev.pgm_err = 1'b1;
        else start_pgm = 1'b1;
      end
      if (trig_rd) begin
        if (rd_blocked) ev.rd_err = 1'b1;
        else start_rd = 1'b1;
      end
    end else begin
      ev.req_err = trig_pgm || trig_rd;
    end
    if (state == ST_PGM_WB) begin
      mem_we      = 1'b1;
      ev.pgm_done = 1'b1;
    end
    if (state == ST_RD_LD) ev.rd_done = 1'b1;
    mem_re    = start_pgm || start_rd;
    mem_raddr = t_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      rd_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_pgm) begin
            state <= ST_PGM_WB;
            row_q <= t_row;
            col_q <= t_col;
          end else if (start_rd) begin
            state <= ST_RD_LD;
          end
        end
        ST_PGM_WB: state <= ST_IDLE;
        ST_RD_LD: begin
          rd_data <= mem_q;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // shadow of the lock fuses; follows the array, so no reset
  always_ff @(posedge clk) begin
    if (mem_we && (mem_waddr == '0)) begin
      lock_q.self_lk <= mem_wd[COLS-1];
      lock_q.grp_a   <= mem_wd[LK_GRP_A];
      lock_q.grp_b   <= mem_wd[LK_GRP_B];
      lock_q.rblk_b  <= mem_wd[RB_GRP_B];
    end
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TA_W   = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  otp_ev_t              ev,
  input  logic [DATA_W-1:0]    rd_row,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq,
  output logic                 pgm_en,
  output logic [DATA_W-1:0]    wlock,
  output logic [IRQ_W-1:0]     isr,
  output logic [IRQ_W-1:0]     imr,
  output logic                 trig_pgm,
  output logic                 trig_rd,
  output logic [TA_W-1:0]      trig_addr
);
  logic             wr_ok;
  logic [IRQ_W-1:0] ev_vec, wbits, w1c;

  always_comb begin
    wr_ok     = wr_en && ((wlock == '0) || (addr == RA_WLOCK));
    trig_pgm  = wr_ok && (addr == RA_PGM);
    trig_rd   = wr_ok && (addr == RA_RD);
    trig_addr = wdata[TA_W-1:0];
    wbits     = wdata[IRQ_W-1:0] & IRQ_IMPL;
    w1c       = (wr_ok && (addr == RA_ISR)) ? wbits : '0;
    ev_vec    = '0;
    ev_vec[IRQ_PGM_DONE] = ev.pgm_done;
    ev_vec[IRQ_RD_DONE]  = ev.rd_done;
    ev_vec[IRQ_PGM_ERR]  = ev.pgm_err;
    ev_vec[IRQ_RD_ERR]   = ev.rd_err;
    ev_vec[IRQ_REQ_ERR]  = ev.req_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_en <= 1'b0;
      wlock  <= '0;
      isr    <= '0;
      imr    <= IRQ_IMPL;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_ok && (addr == RA_CTRL))  pgm_en <= wdata[0];
      if (wr_ok && (addr == RA_WLOCK)) wlock  <= wdata;
      isr <= (isr & ~w1c) | ev_vec;
      if (wr_ok && (addr == RA_IER)) imr <= imr & ~wbits;
      else if (wr_ok && (addr == RA_IDR)) imr <= imr | wbits;
      irq <= |(isr & ~imr);
      if (rd_en) begin
        case (addr)
          RA_CTRL:  rdata <= DATA_W'(pgm_en);
          RA_WLOCK: rdata <= wlock;
          RA_RDATA: rdata <= rd_row;
          RA_ISR:   rdata <= DATA_W'(isr);
          RA_IMR:   rdata <= DATA_W'(imr);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [COLS-1:0]      bus_wdata,
  output logic [COLS-1:0]      bus_rdata,
  output logic                 irq
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int TA_W  = ROW_W + COL_W;

  otp_ev_t          ev;
  logic             pgm_en, trig_pgm, trig_rd;
  logic [TA_W-1:0]  trig_addr;
  logic [COLS-1:0]  wlock, rd_data, mem_q, mem_wd;
  logic [IRQ_W-1:0] isr, imr;
  logic             mem_re, mem_we;
  logic [ROW_W-1:0] mem_raddr, mem_waddr;

  otp_regs #(.DATA_W(COLS), .TA_W(TA_W)) u_regs (
    .clk, .rst,
    .wr_en (bus_wr), .rd_en (bus_rd), .addr (bus_addr), .wdata (bus_wdata),
    .ev, .rd_row (rd_data), .rdata (bus_rdata), .irq,
    .pgm_en, .wlock, .isr, .imr, .trig_pgm, .trig_rd, .trig_addr
  );

  otp_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk, .rst, .trig_pgm, .trig_rd, .trig_addr, .pgm_en,
    .mem_re, .mem_raddr, .mem_q, .mem_we, .mem_waddr, .mem_wd,
    .rd_data, .ev
  );

  otp_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk, .re (mem_re), .raddr (mem_raddr), .q (mem_q),
    .we (mem_we), .waddr (mem_waddr), .wd (mem_wd)
  );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
  import otp_pkg::*;
#(
  parameter int COLS = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [COLS-1:0]    bus_rdata,
  input logic               irq,
  input logic [IRQ_W-1:0]   isr,
  input logic [IRQ_W-1:0]   imr,
  input logic               pgm_en,
  input logic [COLS-1:0]    wlock,
  input logic               mem_we,
  input logic [COLS-1:0]    mem_wd,
  input logic [COLS-1:0]    mem_q,
  input otp_ev_t            ev
);
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && ((bus_addr == RA_PGM) || (bus_addr == RA_RD)) |=> (bus_rdata == '0)); // R2

  AST_PGM_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev.pgm_done, ev.pgm_err})); // R4

  AST_NO_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wd & mem_q) == mem_q)); // R5

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(isr & ~imr)) |=> irq); // R7

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|(isr & ~imr)) |=> !irq); // R7

  AST_MASK_PATH: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && ((bus_addr == RA_IER) || (bus_addr == RA_IDR))) |=> $stable(imr)); // R8

  AST_WLOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (wlock != '0) && bus_wr && (bus_addr == RA_CTRL) |=> $stable(pgm_en)); // R9
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.COLS(COLS)) u_chk (
  .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_rdata, .irq,
  .isr, .imr, .pgm_en, .wlock, .mem_we, .mem_wd, .mem_q, .ev
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [256];
  logic [31:0] last_rd = '0;
  logic [31:0] got;

  always #4 clk = ~clk;

  otp_fuse_ctrl u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] taddr(input int row, input int col);
    return 32'((row << 5) | col);
  endfunction

  // program and check status; ok tells whether the bit should land
  task automatic pgm(input string req, input int row, input int col, input bit ok);
    wr(4'd2, taddr(row, col));
    idle(2);
    if (ok) model[row][col] = 1'b1;
    rd(4'd5, got);
    check(req, got, ok ? 32'h1 : 32'h4);
    wr(4'd5, 32'h10F);
  endtask

  task automatic rdrow(input string req, input int row, input bit ok);
    wr(4'd3, taddr(row, 0));
    idle(2);
    if (ok) last_rd = model[row];
    rd(4'd5, got);
    check(req, got, ok ? 32'h2 : 32'h8);
    wr(4'd5, 32'h10F);
    rd(4'd4, got);
    check(req, got, last_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // reset state: R8 R11
    rd(4'd5, got); check("R11 reset status", got, 32'h0);
    rd(4'd6, got); check("R8 reset mask", got, 32'h10F);
    rd(4'd0, got); check("R3 reset enable", got, 32'h0);
    check("R7 reset irq", 32'(irq), 32'h0);

    // R3: program while disabled
    pgm("R3 disabled program", 1, 3, 0);
    rdrow("R3 row untouched", 1, 1);

    wr(4'd0, 32'h1);
    // R1 R4 R6: sweep every column of row 1
    for (int c = 0; c < 32; c++) begin
      pgm("R4 sweep program", 1, c, 1);
      rd(4'd5, got); check("R11 w1c cleared", got, 32'h0);
      rdrow("R1 column sweep", 1, 1);
    end
    // R1: row field sweep
    for (int r = 2; r < 8; r++) begin
      pgm("R1 row field", r, r, 1);
      rdrow("R1 row readback", r, 1);
    end
    pgm("R1 max field", 255, 31, 1);
    rdrow("R1 max readback", 255, 1);

    // R5: reprogram and add bits
    pgm("R5 reprogram", 1, 0, 1);
    rdrow("R5 full row kept", 1, 1);
    pgm("R5 add bit", 2, 9, 1);
    rdrow("R5 neighbours kept", 2, 1);

    // R2: triggers read back zero
    rd(4'd2, got); check("R2 program trigger reads 0", got, 32'h0);
    rd(4'd3, got); check("R2 read trigger reads 0", got, 32'h0);

    // R12: lock groups
    pgm("R12 row9 before lock", 9, 0, 1);
    pgm("R12 set group A lock", 0, 1, 1);
    for (int r = 8; r < 12; r++) begin
      pgm("R12 group A refused", r, 4, 0);
      rdrow("R12 group A untouched", r, 1);
    end
    pgm("R12 row7 free", 7, 4, 1);
    pgm("R12 row12 free", 12, 5, 1);
    rdrow("R6 row12 readable", 12, 1);
    rdrow("R6 row7 read", 7, 1);
    pgm("R12 set read block", 0, 3, 1);
    rdrow("R6 blocked row12", 12, 0);
    rdrow("R6 blocked row15", 15, 0);
    rdrow("R6 row11 readable", 11, 1);
    rdrow("R6 row16 readable", 16, 1);
    pgm("R12 set group B lock", 0, 2, 1);
    pgm("R12 row13 refused", 13, 0, 0);
    pgm("R12 row16 free", 16, 7, 1);
    pgm("R12 row0 self lock", 0, 31, 1);
    pgm("R12 row0 refused", 0, 20, 0);
    rdrow("R12 row0 contents", 0, 1);
    check("R12 row0 value", model[0], 32'h8000000E);

    // R7 R8: interrupt path
    pgm("R4 masked done", 17, 2, 1);
    wr(4'd2, taddr(17, 3)); idle(3);
    check("R7 masked irq low", 32'(irq), 32'h0);
    model[17][3] = 1'b1;
    wr(4'd7, 32'h1); idle(2);
    check("R7 irq after enable", 32'(irq), 32'h1);
    rd(4'd6, got); check("R8 enable clears mask bit", got, 32'h10E);
    wr(4'd6, 32'h0); idle(1);
    rd(4'd6, got); check("R8 direct mask write ignored", got, 32'h10E);
    wr(4'd8, 32'h1); idle(2);
    check("R7 irq after disable", 32'(irq), 32'h0);
    rd(4'd6, got); check("R8 disable sets mask bit", got, 32'h10F);
    wr(4'd5, 32'h10F);

    // R10: back-to-back triggers
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = taddr(18, 0);
    @(negedge clk); bus_addr = 4'd3; bus_wdata = taddr(18, 0);
    @(negedge clk); bus_wr = 1'b0;
    model[18][0] = 1'b1;
    idle(2);
    rd(4'd5, got); check("R10 request error flagged", got, 32'h101);
    wr(4'd7, 32'h100); idle(2);
    check("R10 irq from request error", 32'(irq), 32'h1);
    wr(4'd8, 32'h100);
    wr(4'd5, 32'h10F);
    rdrow("R10 first op completed", 18, 1);

    // R9: write lock
    wr(4'd1, 32'h5);
    wr(4'd0, 32'h0);
    rd(4'd0, got); check("R9 control frozen", got, 32'h1);
    wr(4'd2, taddr(19, 0)); idle(3);
    rd(4'd5, got); check("R9 trigger ignored", got, 32'h0);
    wr(4'd7, 32'h10F); idle(1);
    rd(4'd6, got); check("R9 mask frozen", got, 32'h10F);
    rd(4'd1, got); check("R9 lock readback", got, 32'h5);
    wr(4'd1, 32'h0);
    rdrow("R9 row19 still blank", 19, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule